// File: doc/BRIEF.md
# Spread-spectrum chip correlator with two decision thresholds

The block turns a direct-sequence chip stream into data bits. Every bit period is a window of 64 or 32 chips, chosen by `mode_short`. Each valid chip is compared with the matching chip of a programmable spreading code, and the number of agreements is counted.

When the window closes, the count is sliced against two separate thresholds. A count at or above the upper one gives a '1'. A count at or below the lower one gives a '0'. A count between the two is flagged as an erasure instead of being forced to a value. The code register and both threshold registers have simple one-cycle write strobes. Each threshold register reads back through its own output.

Chip timing recovery happens upstream. The upstream logic presents one chip per cycle in which `chip_valid` is high. The bit outputs feed a framing stage that can treat erasures as unreliable.

Top module: `dsss_bit_despreader`

## Requirements
- R1: After reset, `bit_valid`, `bit_data` and `bit_erasure` are 0. `thr_hi_rd` reads 0x38 and `thr_lo_rd` reads 0x08.
- R2: A cycle with `thr_hi_wr` (or `thr_lo_wr`) high stores `thr_wdata[6:0]` into the upper (or lower) threshold. From the next cycle the read port returns that value with bit 7 at 0, whatever was written to bit 7.
- R3: A window holds 64 valid chips when `mode_short`=0 and 32 when `mode_short`=1. Cycles with `chip_valid` low do not advance it. Each window produces exactly one single-cycle `bit_valid` pulse, in the cycle after the window's last chip is presented.
- R4: Chips are compared most significant code bit first. Chip k of a window (k from 0) is compared with `pn[63-k]` in 64-chip mode and with `pn[31-k]` in 32-chip mode. A chip counts as a match when it equals that code bit.
- R5: When the window's match count is greater than or equal to the upper threshold, the pulse carries `bit_data`=1 and `bit_erasure`=0.
- R6: When the count is below the upper threshold and less than or equal to the lower threshold, the pulse carries `bit_data`=0 and `bit_erasure`=0.
- R7: When the count lies strictly between the two thresholds, the pulse carries `bit_erasure`=1 and `bit_data` keeps its previous value.
- R8: When the lower threshold is programmed at or above the upper threshold, a count satisfying both tests yields a '1'.
- R9: The match count starts from zero in every window. No agreement carries over from the previous window.
- R10: In a cycle where `mode_short` differs from its value in the previous cycle, the partial window is discarded and the chip index restarts at 0. A chip presented in that cycle is ignored.
- R11: `bit_data` and `bit_erasure` hold their values between `bit_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_short | input | 1 | 1 selects 32-chip windows, 0 selects 64-chip windows |
| pn_wr | input | 1 | Write strobe for the spreading code |
| pn_wdata | input | 64 | Spreading code value; 32-chip mode uses bits 31:0 |
| thr_hi_wr | input | 1 | Write strobe for the upper threshold |
| thr_lo_wr | input | 1 | Write strobe for the lower threshold |
| thr_wdata | input | 8 | Threshold write data; bit 7 is ignored |
| thr_hi_rd | output | 8 | Upper threshold read-back |
| thr_lo_rd | output | 8 | Lower threshold read-back |
| chip_valid | input | 1 | A chip is present this cycle |
| chip_data | input | 1 | Chip value |
| bit_valid | output | 1 | One-cycle pulse at the end of each window |
| bit_data | output | 1 | Decided bit value |
| bit_erasure | output | 1 | The last window fell between the thresholds |

## Verification
The bench builds the block with its default 64-chip and 32-chip code lengths. These are small enough that every error count from 0 up to the full window can be swept in both modes, which places every threshold boundary and every erasure band under direct check. Error positions are spread through each window by a stride permutation, and the code is asymmetric, so a reversed chip order cannot go unnoticed. Extra sweeps with reprogrammed and crossed thresholds cover priority between the two tests, and aborted partial windows cover mode switching.

// File: rtl/dsss_corr_pkg.sv
package dsss_corr_pkg;

  typedef enum logic [1:0] {
    DEC_ZERO  = 2'd0,
    DEC_ONE   = 2'd1,
    DEC_ERASE = 2'd2
  } dec_kind_e;

endpackage

// File: rtl/dsss_cfg_regs.sv
module dsss_cfg_regs #(
  parameter int              LONG_LEN  = 64,
  parameter int              THR_W     = 7,
  parameter int              THR_REG_W = THR_W + 1,
  parameter logic [LONG_LEN-1:0] PN_RESET  = '0,
  parameter logic [THR_W-1:0]    HI_RESET  = 7'h38,
  parameter logic [THR_W-1:0]    LO_RESET  = 7'h08
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pn_wr,
  input  logic [LONG_LEN-1:0]  pn_wdata,
  input  logic                 thr_hi_wr,
  input  logic                 thr_lo_wr,
  input  logic [THR_REG_W-1:0] thr_wdata,
  output logic [LONG_LEN-1:0]  pn_q,
  output logic [THR_W-1:0]     thr_hi_q,
  output logic [THR_W-1:0]     thr_lo_q,
  output logic [THR_REG_W-1:0] thr_hi_rd,
  output logic [THR_REG_W-1:0] thr_lo_rd
);

  localparam int PAD_W = THR_REG_W - THR_W;

  logic [LONG_LEN-1:0] pn_d;
  logic [THR_W-1:0]    hi_d;
  logic [THR_W-1:0]    lo_d;

  always_comb begin
    pn_d = pn_wdata;
    hi_d = thr_wdata[THR_W-1:0];
    lo_d = thr_wdata[THR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pn_q <= PN_RESET;
    end else if (pn_wr) begin
      pn_q <= pn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hi_q <= HI_RESET;
    end else if (thr_hi_wr) begin
      thr_hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_lo_q <= LO_RESET;
    end else if (thr_lo_wr) begin
      thr_lo_q <= lo_d;
    end
  end

  // Reserved upper bits always read as zero.
  assign thr_hi_rd = {{PAD_W{1'b0}}, thr_hi_q};
  assign thr_lo_rd = {{PAD_W{1'b0}}, thr_lo_q};

  // R2: read-back equals the written word with reserved bits cleared
  assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hi_wr |=> thr_hi_rd == ($past(thr_wdata) & {{PAD_W{1'b0}}, {THR_W{1'b1}}}));

  assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_lo_wr |=> thr_lo_rd == ($past(thr_wdata) & {{PAD_W{1'b0}}, {THR_W{1'b1}}}));

endmodule

// File: rtl/dsss_chip_index.sv
module dsss_chip_index #(
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 32,
  parameter int IDX_W     = $clog2(LONG_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_valid,
  input  logic             mode_short,
  output logic [IDX_W-1:0] idx,
  output logic             win_first,
  output logic             win_last,
  output logic             chip_take
);

  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(LONG_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_LEN - 1);

  logic             mode_q;
  logic             restart;
  logic             idx_en;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] last_idx;

  always_comb begin
    restart   = mode_short ^ mode_q;
    chip_take = chip_valid & ~restart;
    last_idx  = mode_short ? LAST_SHORT : LAST_LONG;
    win_first = (idx == '0);
    win_last  = (idx == last_idx);
    idx_en    = chip_take | restart;
    if (restart || win_last) begin
      idx_d = '0;
    end else begin
      idx_d = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_short;
    end
  end

  // R3: outside a mode change the index never leaves the active window
  assert_idx_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> idx <= last_idx);

  // R3: idle cycles leave the position untouched
  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_valid && !restart) |=> $stable(idx));

  // R10: a mode change restarts the window
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> idx == '0);

endmodule

// File: rtl/dsss_match_acc.sv
module dsss_match_acc #(
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 32,
  parameter int IDX_W     = $clog2(LONG_LEN),
  parameter int CNT_W     = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LONG_LEN-1:0] pn_q,
  input  logic                mode_short,
  input  logic [IDX_W-1:0]    idx,
  input  logic                win_first,
  input  logic                chip_take,
  input  logic                chip_data,
  output logic [CNT_W-1:0]    sum_now
);

  localparam int SIDX_W = $clog2(SHORT_LEN);

  logic [LONG_LEN-1:0]  seq_long;
  logic [SHORT_LEN-1:0] seq_short;
  logic                 ref_chip;
  logic                 match;
  logic [CNT_W-1:0]     count_q;
  logic [CNT_W-1:0]     base;

  // Reorder the code so index k addresses the k-th chip sent (MSB first).
  for (genvar gi = 0; gi < LONG_LEN; gi++) begin : g_long
    assign seq_long[gi] = pn_q[LONG_LEN-1-gi];
  end
  for (genvar gj = 0; gj < SHORT_LEN; gj++) begin : g_short
    assign seq_short[gj] = pn_q[SHORT_LEN-1-gj];
  end

  always_comb begin
    ref_chip = mode_short ? seq_short[idx[SIDX_W-1:0]] : seq_long[idx];
    match    = chip_take & ~(chip_data ^ ref_chip);
    base     = win_first ? '0 : count_q;
    sum_now  = base + CNT_W'(match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (chip_take) begin
      count_q <= sum_now;
    end
  end

  // R9: a running total can never exceed the chips seen in the window
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chip_take |-> sum_now <= ({1'b0, idx} + 1'b1));

endmodule

// File: rtl/dsss_bit_slicer.sv
module dsss_bit_slicer
  import dsss_corr_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide_en,
  input  logic [CNT_W-1:0] sum_now,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             bit_erasure
);

  dec_kind_e dec;
  logic      hit_one;
  logic      hit_zero;
  logic      data_d;
  logic      era_d;

  always_comb begin
    hit_one  = (sum_now >= thr_hi);
    hit_zero = (sum_now <= thr_lo);
    if (hit_one) begin
      dec = DEC_ONE;
    end else if (hit_zero) begin
      dec = DEC_ZERO;
    end else begin
      dec = DEC_ERASE;
    end
    data_d = bit_data;
    era_d  = 1'b1;
    case (dec)
      DEC_ONE:  begin data_d = 1'b1; era_d = 1'b0; end
      DEC_ZERO: begin data_d = 1'b0; era_d = 1'b0; end
      default:  begin data_d = bit_data; era_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= decide_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_data    <= 1'b0;
      bit_erasure <= 1'b0;
    end else if (decide_en) begin
      bit_data    <= data_d;
      bit_erasure <= era_d;
    end
  end

  // R8: an upper-threshold hit always lands as a clean '1'
  assert_one_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_en && (sum_now >= thr_hi)) |=> (bit_data && !bit_erasure));

  // R7: an erasure leaves the data bit as it was
  assert_erasure_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_erasure) |-> bit_data == $past(bit_data));

  // R11: outputs are frozen between decisions
  assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> ($stable(bit_data) && $stable(bit_erasure)));

endmodule

// File: rtl/dsss_bit_despreader.sv
module dsss_bit_despreader #(
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 32,
  parameter int IDX_W     = $clog2(LONG_LEN),
  parameter int CNT_W     = IDX_W + 1,
  parameter int THR_REG_W = CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_short,
  input  logic                 pn_wr,
  input  logic [LONG_LEN-1:0]  pn_wdata,
  input  logic                 thr_hi_wr,
  input  logic                 thr_lo_wr,
  input  logic [THR_REG_W-1:0] thr_wdata,
  output logic [THR_REG_W-1:0] thr_hi_rd,
  output logic [THR_REG_W-1:0] thr_lo_rd,
  input  logic                 chip_valid,
  input  logic                 chip_data,
  output logic                 bit_valid,
  output logic                 bit_data,
  output logic                 bit_erasure
);

  logic [1:0]          rst_sync;
  logic                rst_core_n;
  logic [LONG_LEN-1:0] pn_q;
  logic [CNT_W-1:0]    thr_hi_q;
  logic [CNT_W-1:0]    thr_lo_q;
  logic [IDX_W-1:0]    idx;
  logic                win_first;
  logic                win_last;
  logic                chip_take;
  logic [CNT_W-1:0]    sum_now;
  logic                decide_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  dsss_cfg_regs #(
    .LONG_LEN  (LONG_LEN),
    .THR_W     (CNT_W),
    .THR_REG_W (THR_REG_W),
    .PN_RESET  ('0),
    .HI_RESET  (CNT_W'(7'h38)),
    .LO_RESET  (CNT_W'(7'h08))
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pn_wr     (pn_wr),
    .pn_wdata  (pn_wdata),
    .thr_hi_wr (thr_hi_wr),
    .thr_lo_wr (thr_lo_wr),
    .thr_wdata (thr_wdata),
    .pn_q      (pn_q),
    .thr_hi_q  (thr_hi_q),
    .thr_lo_q  (thr_lo_q),
    .thr_hi_rd (thr_hi_rd),
    .thr_lo_rd (thr_lo_rd)
  );

  dsss_chip_index #(
    .LONG_LEN  (LONG_LEN),
    .SHORT_LEN (SHORT_LEN),
    .IDX_W     (IDX_W)
  ) u_index (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .chip_valid (chip_valid),
    .mode_short (mode_short),
    .idx        (idx),
    .win_first  (win_first),
    .win_last   (win_last),
    .chip_take  (chip_take)
  );

  dsss_match_acc #(
    .LONG_LEN  (LONG_LEN),
    .SHORT_LEN (SHORT_LEN),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .pn_q       (pn_q),
    .mode_short (mode_short),
    .idx        (idx),
    .win_first  (win_first),
    .chip_take  (chip_take),
    .chip_data  (chip_data),
    .sum_now    (sum_now)
  );

  assign decide_en = chip_take & win_last;

  dsss_bit_slicer #(
    .CNT_W (CNT_W)
  ) u_slicer (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .decide_en   (decide_en),
    .sum_now     (sum_now),
    .thr_hi      (thr_hi_q),
    .thr_lo      (thr_lo_q),
    .bit_valid   (bit_valid),
    .bit_data    (bit_data),
    .bit_erasure (bit_erasure)
  );

  // R3: a decision pulse always follows a presented chip
  assert_pulse_after_chip_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    bit_valid |-> $past(chip_valid));

  // R3: the pulse lasts a single cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    bit_valid |=> !bit_valid);

endmodule

// File: tb/test_dsss_bit_despreader.sv
module test_dsss_bit_despreader;

  localparam logic [63:0] PN = 64'hF0E1_D2C3_3A5B_6C7D;

  logic        clk;
  logic        rst_n;
  logic        mode_short;
  logic        pn_wr;
  logic [63:0] pn_wdata;
  logic        thr_hi_wr;
  logic        thr_lo_wr;
  logic [7:0]  thr_wdata;
  logic [7:0]  thr_hi_rd;
  logic [7:0]  thr_lo_rd;
  logic        chip_valid;
  logic        chip_data;
  logic        bit_valid;
  logic        bit_data;
  logic        bit_erasure;

  int n_tests;
  int n_fail;
  int cur_hi;
  int cur_lo;
  logic exp_data;

  dsss_bit_despreader i_dsss_bit_despreader (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_short  (mode_short),
    .pn_wr       (pn_wr),
    .pn_wdata    (pn_wdata),
    .thr_hi_wr   (thr_hi_wr),
    .thr_lo_wr   (thr_lo_wr),
    .thr_wdata   (thr_wdata),
    .thr_hi_rd   (thr_hi_rd),
    .thr_lo_rd   (thr_lo_rd),
    .chip_valid  (chip_valid),
    .chip_data   (chip_data),
    .bit_valid   (bit_valid),
    .bit_data    (bit_data),
    .bit_erasure (bit_erasure)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_hi(input logic [7:0] v);
    @(negedge clk);
    thr_hi_wr = 1'b1; thr_wdata = v;
    @(negedge clk);
    thr_hi_wr = 1'b0;
    cur_hi = int'(v[6:0]);
  endtask

  task automatic set_lo(input logic [7:0] v);
    @(negedge clk);
    thr_lo_wr = 1'b1; thr_wdata = v;
    @(negedge clk);
    thr_lo_wr = 1'b0;
    cur_lo = int'(v[6:0]);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_short = m;
    @(negedge clk);
  endtask

  function automatic logic ref_bit(input int len, input int k);
    return (len == 32) ? PN[31-k] : PN[63-k];
  endfunction

  // Window with exactly errs wrong chips, spread by a stride permutation.
  task automatic run_window(input string req, input int len, input int errs, input int gaps);
    int early = 0;
    int m;
    logic ed, ee;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (bit_valid) early++;
      if (gaps != 0 && (k % 5) == 2) begin
        chip_valid = 1'b0;
        @(negedge clk);
        if (bit_valid) early++;
      end
      chip_valid = 1'b1;
      chip_data  = ref_bit(len, k) ^ (((k * 7 + errs) % len) < errs);
    end
    @(negedge clk);
    chip_valid = 1'b0;
    m = len - errs;
    if (m >= cur_hi) begin ed = 1'b1; ee = 1'b0; end
    else if (m <= cur_lo) begin ed = 1'b0; ee = 1'b0; end
    else begin ed = exp_data; ee = 1'b1; end
    exp_data = ed;
    check(req, {early[7:0], 5'd0, bit_valid, bit_erasure, bit_data}, {8'd0, 5'd0, 1'b1, ee, ed});
    @(negedge clk);
    check("R3 pulse one cycle / R11 hold", {29'd0, bit_valid, bit_erasure, bit_data}, {29'd0, 1'b0, ee, ed});
  endtask

  task automatic partial(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chip_valid = 1'b1;
      chip_data  = ~ref_bit(64, k);
    end
    @(negedge clk);
    chip_valid = 1'b0;
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; mode_short = 1'b0; pn_wr = 1'b0; pn_wdata = '0;
    thr_hi_wr = 1'b0; thr_lo_wr = 1'b0; thr_wdata = '0;
    chip_valid = 1'b0; chip_data = 1'b0;
    exp_data = 1'b0; cur_hi = 56; cur_lo = 8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 outputs", {29'd0, bit_valid, bit_data, bit_erasure}, 32'd0);
    check("R1 thr_hi", {24'd0, thr_hi_rd}, 32'h38);
    check("R1 thr_lo", {24'd0, thr_lo_rd}, 32'h08);

    // R2 reserved bit ignored
    set_hi(8'hFF);
    check("R2 hi reserved", {24'd0, thr_hi_rd}, 32'h7F);
    set_lo(8'hC5);
    check("R2 lo reserved", {24'd0, thr_lo_rd}, 32'h45);
    set_hi(8'h38);
    set_lo(8'h08);
    check("R2 hi restore", {24'd0, thr_hi_rd}, 32'h38);

    @(negedge clk);
    pn_wr = 1'b1; pn_wdata = PN;
    @(negedge clk);
    pn_wr = 1'b0;

    // R4 R5 R6 R7 R9: full error sweep, 64-chip mode, default thresholds
    for (int e = 0; e <= 64; e++) run_window("R5/R6/R7/R4/R9 64-chip sweep", 64, e, 0);

    // R3 idle cycles inside a window
    run_window("R3 gaps 64", 64, 3, 1);
    run_window("R3 gaps 64 zero", 64, 60, 1);

    // 32-chip mode, thresholds 24/8
    set_hi(8'd24);
    set_lo(8'd8);
    set_mode(1'b1);
    for (int e = 0; e <= 32; e++) run_window("R5/R6/R7/R4/R3 32-chip sweep", 32, e, 0);
    run_window("R3 gaps 32", 32, 20, 1);

    // Erasure after a '1' keeps data at 1
    run_window("R7 after one", 32, 0, 0);
    run_window("R7 erase keeps one", 32, 16, 0);

    // R8 crossed thresholds: lo above hi
    set_hi(8'd20);
    set_lo(8'd26);
    for (int e = 0; e <= 32; e++) run_window("R8 crossed 32", 32, e, 0);

    // R10 switch short->long after partial window
    set_hi(8'h38);
    set_lo(8'h08);
    partial(10);
    set_mode(1'b0);
    run_window("R10 short to long", 64, 64, 0);
    run_window("R10 long follow-on", 64, 0, 0);

    // R10 switch long->short after partial window
    set_hi(8'd24);
    partial(40);
    set_mode(1'b1);
    run_window("R10 long to short", 32, 0, 0);
    run_window("R10 short zero", 32, 31, 0);

    // Custom thresholds in 64-chip mode around boundaries
    set_mode(1'b0);
    set_hi(8'd40);
    set_lo(8'd20);
    for (int e = 20; e <= 48; e++) run_window("R5/R6/R7 custom 64", 64, e, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule